// File: doc/BRIEF.md
# Delayed Branch Sequencer

This block keeps the program counter of a small in-order processor front end that has one branch delay slot. Each cycle it presents a fetch address, and decode reports what the instruction at that address is. A branch may be pc-relative and unconditional, register-indirect, or pc-relative and conditional on a single compare flag. The instruction that follows any branch is a delay-slot instruction. It always executes, and only once it has been accepted does the fetch address move to the branch target. If the branch was not taken, fetch continues in sequence instead.

The target is worked out and latched when the branch is accepted. A register write made by the slot instruction therefore cannot change where the branch goes. A branch that decode finds inside a delay slot is not taken. It produces a one-cycle error pulse, and the redirect already pending goes ahead unchanged. A decode stall freezes the sequencer completely.

The controller has three named states. RUN is the normal sequential state. SLOT_JUMP means the current instruction is a slot and a captured target is waiting. SLOT_FALL means the current instruction is a slot of a branch that was not taken. The transitions below all take place only on a cycle without a stall:
- RUN goes to SLOT_JUMP on a taken branch.
- RUN goes to SLOT_FALL on a branch that is not taken.
- RUN stays in RUN on any other instruction.
- SLOT_JUMP goes to RUN and loads the captured target.
- SLOT_FALL goes to RUN and steps the address.

Top module: `dly_branch_seq`

## Requirements
- R1: While reset is low, and in the first cycle after reset, the fetch address is 0, the slot indication is 0 and the error pulse is 0. The valid output is 0 during reset.
- R2: In RUN, an accepted instruction that is not a branch moves the fetch address on by 2. The branch-kind code for this is 0, or any code from 5 to 7.
- R3: An accepted branch (kind codes 1 to 4) makes the next fetch address equal to the branch address plus 2, with the slot indication at 1. After a slot instruction has been accepted, the slot indication returns to 0.
- R4: A pc-relative taken branch (kind 1, or kind 3 or 4 when taken) redirects, after its slot, to the branch address + 4 + 2 × the displacement. The displacement is a 12-bit two's-complement value.
- R5: A register-indirect branch (kind 2) redirects, after its slot, to the register value presented with the branch. A different register value presented during the slot has no effect.
- R6: Kind 3 is taken when the flag is 1, and kind 4 is taken when the flag is 0. A branch that is not taken still has a slot, after which fetch continues at the branch address + 4.
- R7: A branch accepted in a slot is not taken. The error output is 1 for exactly the following cycle, and the fetch address moves to wherever the first branch decided.
- R8: While stall is 1, the fetch address, the slot indication and the pending target hold, and the error output is 0.
- R9: The valid output is 1 exactly when reset is high and stall is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Decode stall; freezes all state |
| br_kind_i | input | 3 | Kind of the decoded instruction (0 none, 1 rel, 2 reg, 3 cond-true, 4 cond-false) |
| disp_i | input | DW (12) | Signed displacement of pc-relative branches |
| reg_val_i | input | AW (32) | Register value read for the current instruction |
| flag_i | input | 1 | Compare flag from the status register |
| pc_o | output | AW (32) | Fetch address |
| slot_o | output | 1 | Instruction at pc_o is a delay-slot instruction |
| valid_o | output | 1 | Instruction at pc_o is accepted this cycle |
| illegal_o | output | 1 | Pulse: a branch was accepted inside a slot |

## Verification
Directed sequences cover the following cases:
- Positive, negative and extreme displacements, which expose errors in sign extension and in the +4 offset.
- A register-indirect branch whose slot presents a new register value, which tells a captured target apart from a live read.
- Both condition senses with both flag values, which separate taken paths from fall-through paths.
- A branch placed inside a slot, and a stall held inside a slot.

A long stretch of seeded random kinds, flags and stalls then mixes every transition with every other one. The outputs are compared each cycle with a bench model of the three states.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    typedef enum logic [2:0] {
        BK_NONE   = 3'd0,
        BK_REL    = 3'd1,
        BK_REG    = 3'd2,
        BK_COND_T = 3'd3,
        BK_COND_F = 3'd4
    } br_kind_e;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_SLOT_JUMP = 2'd1,
        ST_SLOT_FALL = 2'd2
    } seq_state_e;

endpackage

// File: rtl/dbs_take_eval.sv
module dbs_take_eval
    import dbs_pkg::*;
(
    input  logic [2:0] kind_i,
    input  logic       flag_i,
    output logic       is_br_o,
    output logic       take_o,
    output logic       use_reg_o
);

    always_comb begin
        is_br_o   = 1'b0;
        take_o    = 1'b0;
        use_reg_o = 1'b0;
        unique case (kind_i)
            BK_REL: begin
                is_br_o = 1'b1;
                take_o  = 1'b1;
            end
            BK_REG: begin
                is_br_o   = 1'b1;
                take_o    = 1'b1;
                use_reg_o = 1'b1;
            end
            BK_COND_T: begin
                is_br_o = 1'b1;
                take_o  = flag_i;
            end
            BK_COND_F: begin
                is_br_o = 1'b1;
                take_o  = ~flag_i;
            end
            default: begin
                is_br_o   = 1'b0;
                take_o    = 1'b0;
                use_reg_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dbs_target.sv
module dbs_target #(
    parameter int AW   = 32,
    parameter int DW   = 12,
    parameter int STEP = 2
) (
    input  logic [AW-1:0] pc_i,
    input  logic [DW-1:0] disp_i,
    input  logic [AW-1:0] reg_val_i,
    input  logic          use_reg_i,
    output logic [AW-1:0] tgt_o
);

    localparam int            SHIFT   = $clog2(STEP);
    localparam logic [AW-1:0] REL_OFS = AW'(2 * STEP);

    logic [AW-1:0] disp_ext;
    logic [AW-1:0] rel_tgt;

    generate
        if (AW > DW) begin : g_ext
            assign disp_ext = {{(AW-DW){disp_i[DW-1]}}, disp_i};
        end else begin : g_trunc
            assign disp_ext = disp_i[AW-1:0];
        end
    endgenerate

    assign rel_tgt = pc_i + REL_OFS + (disp_ext << SHIFT);
    assign tgt_o   = use_reg_i ? reg_val_i : rel_tgt;

endmodule

// File: rtl/dly_branch_seq.sv
module dly_branch_seq
    import dbs_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 12,
    parameter int STEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall_i,
    input  logic [2:0]    br_kind_i,
    input  logic [DW-1:0] disp_i,
    input  logic [AW-1:0] reg_val_i,
    input  logic          flag_i,
    output logic [AW-1:0] pc_o,
    output logic          slot_o,
    output logic          valid_o,
    output logic          illegal_o
);

    localparam logic [AW-1:0] STEP_A = AW'(STEP);

    seq_state_e    state_q, state_d;
    logic [AW-1:0] pc_q, pc_d;
    logic [AW-1:0] tgt_q, tgt_d;
    logic          ill_q, ill_d;

    logic          is_br, take, use_reg;
    logic [AW-1:0] tgt_calc;

    dbs_take_eval u_eval (
        .kind_i    (br_kind_i),
        .flag_i    (flag_i),
        .is_br_o   (is_br),
        .take_o    (take),
        .use_reg_o (use_reg)
    );

    dbs_target #(.AW(AW), .DW(DW), .STEP(STEP)) u_tgt (
        .pc_i      (pc_q),
        .disp_i    (disp_i),
        .reg_val_i (reg_val_i),
        .use_reg_i (use_reg),
        .tgt_o     (tgt_calc)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            tgt_q <= '0;
            ill_q <= 1'b0;
        end else begin
            pc_q  <= pc_d;
            tgt_q <= tgt_d;
            ill_q <= ill_d;
        end
    end

    // next state and datapath
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        tgt_d   = tgt_q;
        ill_d   = 1'b0;
        if (!stall_i) begin
            unique case (state_q)
                ST_RUN: begin
                    pc_d = pc_q + STEP_A;
                    if (is_br) begin
                        if (take) begin
                            state_d = ST_SLOT_JUMP;
                            tgt_d   = tgt_calc;
                        end else begin
                            state_d = ST_SLOT_FALL;
                        end
                    end
                end
                ST_SLOT_JUMP: begin
                    pc_d    = tgt_q;
                    state_d = ST_RUN;
                    ill_d   = is_br;
                end
                ST_SLOT_FALL: begin
                    pc_d    = pc_q + STEP_A;
                    state_d = ST_RUN;
                    ill_d   = is_br;
                end
                default: begin
                    state_d = ST_RUN;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        pc_o      = pc_q;
        slot_o    = (state_q != ST_RUN);
        valid_o   = rst_n & ~stall_i;
        illegal_o = ill_q;
    end

endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
    parameter int AW   = 32,
    parameter int DW   = 12,
    parameter int STEP = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stall_i,
    input logic [2:0]    br_kind_i,
    input logic [DW-1:0] disp_i,
    input logic [AW-1:0] reg_val_i,
    input logic          flag_i,
    input logic [AW-1:0] pc_o,
    input logic          slot_o,
    input logic          valid_o,
    input logic          illegal_o
);

    logic          br_w;
    logic [AW-1:0] rel_w;

    assign br_w  = (br_kind_i >= 3'd1) && (br_kind_i <= 3'd4);
    assign rel_w = pc_o + AW'(2 * STEP) + ({{(AW-DW){disp_i[DW-1]}}, disp_i} << 1);

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_o && !stall_i && !br_w |=> pc_o == $past(pc_o) + AW'(STEP)); // R2

    AST_SLOT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_o && !stall_i && br_w |=> slot_o && pc_o == $past(pc_o) + AW'(STEP)); // R3

    AST_REL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_o && !stall_i && br_kind_i == 3'd1 ##1 !stall_i |=> pc_o == $past(rel_w, 2)); // R4

    AST_REG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_o && !stall_i && br_kind_i == 3'd2 ##1 !stall_i |=> pc_o == $past(reg_val_i, 2)); // R5

    AST_COND_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_o && !stall_i && br_kind_i == 3'd3 && !flag_i ##1 !stall_i
        |=> pc_o == $past(pc_o, 2) + AW'(2 * STEP)); // R6

    AST_SLOT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        slot_o && !stall_i && br_w |=> illegal_o && !slot_o); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> $stable(pc_o) && $stable(slot_o) && !illegal_o); // R8

    AST_VALID_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> !valid_o); // R9

endmodule

bind dly_branch_seq dbs_checker #(.AW(AW), .DW(DW), .STEP(STEP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall_i   (stall_i),
    .br_kind_i (br_kind_i),
    .disp_i    (disp_i),
    .reg_val_i (reg_val_i),
    .flag_i    (flag_i),
    .pc_o      (pc_o),
    .slot_o    (slot_o),
    .valid_o   (valid_o),
    .illegal_o (illegal_o)
);

// File: tb/tb_dly_branch_seq.sv
module tb_dly_branch_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_i = 1'b0;
    logic [2:0]  br_kind_i = 3'd0;
    logic [11:0] disp_i = 12'd0;
    logic [31:0] reg_val_i = 32'd0;
    logic        flag_i = 1'b0;
    logic [31:0] pc_o;
    logic        slot_o, valid_o, illegal_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model: 0 RUN, 1 SLOT_JUMP, 2 SLOT_FALL
    logic [31:0] m_pc = 32'd0;
    logic [31:0] m_tgt = 32'd0;
    int          m_st = 0;
    logic        m_ill = 1'b0;
    string       m_tag = "R1";
    string       m_jtag = "R4";

    always #10 clk = ~clk;

    dly_branch_seq dut (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .br_kind_i(br_kind_i),
        .disp_i(disp_i), .reg_val_i(reg_val_i), .flag_i(flag_i),
        .pc_o(pc_o), .slot_o(slot_o), .valid_o(valid_o), .illegal_o(illegal_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rel_tgt(input logic [31:0] pc, input logic [11:0] d);
        return pc + 32'd4 + 32'($signed(d)) * 32'd2;
    endfunction

    task automatic step(input logic [2:0] k, input logic [11:0] d, input logic [31:0] rv,
                        input logic fl, input logic st);
        bit br, take;
        br_kind_i = k; disp_i = d; reg_val_i = rv; flag_i = fl; stall_i = st;
        #1;
        chk("R9", 32'(valid_o), 32'(!st));
        br   = (k >= 3'd1) && (k <= 3'd4);
        take = (k == 3'd1) || (k == 3'd2) || (k == 3'd3 && fl) || (k == 3'd4 && !fl);
        if (st) begin
            m_ill = 1'b0;
            m_tag = "R8";
        end else if (m_st == 0) begin
            m_ill = 1'b0;
            if (br) begin
                m_st  = take ? 1 : 2;
                m_tag = "R3";
                if (take) begin
                    m_tgt  = (k == 3'd2) ? rv : rel_tgt(m_pc, d);
                    m_jtag = (k == 3'd2) ? "R5" : ((k == 3'd1) ? "R4" : "R6");
                end
            end else begin
                m_tag = "R2";
            end
            m_pc = m_pc + 32'd2;
        end else begin
            m_ill = br;
            m_tag = br ? "R7" : ((m_st == 1) ? m_jtag : "R6");
            m_pc  = (m_st == 1) ? m_tgt : m_pc + 32'd2;
            m_st  = 0;
        end
        @(negedge clk);
        chk(m_tag, pc_o, m_pc);
        chk(m_tag, 32'(slot_o), 32'(m_st != 0));
        chk(m_tag, 32'(illegal_o), 32'(m_ill));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1", pc_o, 32'd0);
        chk("R1", 32'(slot_o), 32'd0);
        chk("R1", 32'(illegal_o), 32'd0);
        chk("R1", 32'(valid_o), 32'd0);
        rst_n = 1'b1;
        #1;
        chk("R1", pc_o, 32'd0);
        // R2 sequential
        step(3'd0, 12'h0, 32'h0, 1'b0, 1'b0);
        step(3'd6, 12'h0, 32'h0, 1'b0, 1'b0);
        // R4 positive, negative, extreme displacements
        step(3'd1, 12'h005, 32'h0, 1'b0, 1'b0);
        step(3'd0, 12'h0, 32'h0, 1'b0, 1'b0);
        step(3'd1, 12'hFFD, 32'h0, 1'b0, 1'b0);
        step(3'd0, 12'h0, 32'h0, 1'b0, 1'b0);
        step(3'd1, 12'h7FF, 32'h0, 1'b0, 1'b0);
        step(3'd0, 12'h0, 32'h0, 1'b0, 1'b0);
        step(3'd1, 12'h800, 32'h0, 1'b0, 1'b0);
        step(3'd0, 12'h0, 32'h0, 1'b0, 1'b0);
        // R5 slot writes the target register
        step(3'd2, 12'h0, 32'h0000_0100, 1'b0, 1'b0);
        step(3'd0, 12'h0, 32'h0000_0200, 1'b0, 1'b0);
        // R6 both senses, both flags
        step(3'd3, 12'h010, 32'h0, 1'b1, 1'b0);
        step(3'd0, 12'h0, 32'h0, 1'b0, 1'b0);
        step(3'd3, 12'h010, 32'h0, 1'b0, 1'b0);
        step(3'd0, 12'h0, 32'h0, 1'b1, 1'b0);
        step(3'd4, 12'h020, 32'h0, 1'b0, 1'b0);
        step(3'd0, 12'h0, 32'h0, 1'b0, 1'b0);
        step(3'd4, 12'h020, 32'h0, 1'b1, 1'b0);
        step(3'd0, 12'h0, 32'h0, 1'b0, 1'b0);
        // R7 branch in slot, taken and fall-through cases
        step(3'd1, 12'h040, 32'h0, 1'b0, 1'b0);
        step(3'd2, 12'h0, 32'h0000_0800, 1'b0, 1'b0);
        step(3'd0, 12'h0, 32'h0, 1'b0, 1'b0);
        step(3'd3, 12'h040, 32'h0, 1'b0, 1'b0);
        step(3'd1, 12'h100, 32'h0, 1'b0, 1'b0);
        step(3'd0, 12'h0, 32'h0, 1'b0, 1'b0);
        // R8 stall inside a slot, and a branch under stall
        step(3'd2, 12'h0, 32'h0000_0A00, 1'b0, 1'b0);
        step(3'd1, 12'h0, 32'h0000_0B00, 1'b0, 1'b1);
        step(3'd2, 12'h0, 32'h0000_0C00, 1'b0, 1'b1);
        step(3'd0, 12'h0, 32'h0000_0D00, 1'b0, 1'b1);
        step(3'd0, 12'h0, 32'h0, 1'b0, 1'b0);
        step(3'd1, 12'h0, 32'h0, 1'b0, 1'b1);
        step(3'd0, 12'h0, 32'h0, 1'b0, 1'b0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [2:0]  k;
            logic [11:0] d;
            logic [31:0] rv;
            k  = 3'($urandom % 8);
            d  = 12'($urandom);
            rv = $urandom & 32'hFFFF_FFFE;
            step(k, d, rv, 1'($urandom), ($urandom % 5) == 0);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule